// File: doc/BRIEF.md
# Phase Comparator with Lock Detect

This block compares two single-cycle pulse trains inside a synthesizer loop: one from the divided reference and one from the divided feedback. Both are already in the sampling-clock domain. It produces two pump requests: "raise" when the reference leads and "lower" when the feedback leads. These requests are presented two ways. The first is a pair of active-low pins for an external charge pump. The second is an output-enable and level pair that drives an internal tri-state pump.

A lock flag watches how wide the phase error is in each comparison. A run input opens or closes the loop. While the block is held in standby, no pump is driven and the lock flag is cleared. When the run input goes high again, the block issues a one-cycle restart strobe. The dividers use this strobe to reload together, so the first comparison after start-up begins near zero phase error. This is the fast pull-in mechanism.

The control and status pins are plain levels. There is no streamed data interface.

Top module: `pfd_lock_top`

## Requirements
- R1: While rst_n is low, ext_up_n and ext_dn_n are 1, and lock, pump_en, pump_oe, pump_src and div_restart are 0.
- R2: The run input is registered once. One cycle after ps_run is sampled low, pump_en and lock are 0 and ext_up_n, ext_dn_n are 1, with pump_oe 0. Pulses on ref_pulse or div_pulse during standby change none of these outputs.
- R3: The first clock edge that samples ps_run high after a low raises pump_en and div_restart. div_restart stays high for exactly one cycle.
- R4: A ref_pulse sampled at an edge makes ext_up_n 0 after that edge. A div_pulse does the same for ext_dn_n. Each request holds until it is cleared.
- R5: Once both requests are active, both clear at the next edge. A pulse sampled on that same clearing edge starts a new request at once.
- R6: pump_oe is 1 only when pump_en is 1 and exactly one request is active. pump_src is then 1 for raise and 0 for lower. With both or neither active, pump_oe is 0.
- R7: The error width of a comparison is the number of cycles in which exactly one request was active. A comparison counts as good when that width is below LOCK_TOL (default 2).
- R8: lock rises after LOCK_COUNT (default 4) consecutive good comparisons. It becomes visible on the cycle after both requests were active in the last of them.
- R9: A single comparison that is not good drops lock at the same point in time and restarts the count.
- R10: In the restart cycle the request state, the error count and the good count are cleared, and pulses sampled in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_run | input | 1 | 1 = operate, 0 = standby (loop open) |
| ref_pulse | input | 1 | One-cycle pulse from the reference divider |
| div_pulse | input | 1 | One-cycle pulse from the feedback divider |
| ext_up_n | output | 1 | Active-low raise request for an external pump |
| ext_dn_n | output | 1 | Active-low lower request for an external pump |
| lock | output | 1 | 1 = loop locked |
| pump_en | output | 1 | Pump enable; 0 means the loop is open |
| pump_oe | output | 1 | Internal pump drive enable (0 = high impedance) |
| pump_src | output | 1 | Internal pump level when enabled: 1 source, 0 sink |
| div_restart | output | 1 | One-cycle strobe to reload both dividers aligned |

## Verification
The hardest situations to reach from the ports involve pulses that land on special cycles. One case is a fresh pulse that arrives on the very edge that clears a finished comparison. The other is a pulse sampled during the restart cycle. The bench times each pulse at a known negative edge relative to the requests it has already opened. It sweeps the lead/lag spacing in both directions across the lock tolerance, and it tracks the good-comparison count arithmetically. This shows lock rising and falling at the predicted comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_req_t;
endpackage

// File: rtl/pfd_run_ctrl.sv
module pfd_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ps_run,
  output logic run,
  output logic restart
);
  logic ps_q, ps_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= 1'b0;
      ps_d2 <= 1'b0;
    end else begin
      ps_q  <= ps_run;
      ps_d2 <= ps_q;
    end
  end

  assign run     = ps_q;
  assign restart = ps_q & ~ps_d2;

  // R3: the strobe lasts one cycle and follows a sampled high level
  p_restart_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  p_restart_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $past(ps_run));
endmodule

// File: rtl/pfd_req_core.sv
module pfd_req_core
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  logic     ref_pulse,
  input  logic     div_pulse,
  output pfd_req_t req
);
  logic both;
  assign both = req.up & req.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= '0;
    end else if (!run || restart) begin
      req <= '0;
    end else if (both) begin
      req.up <= ref_pulse;
      req.dn <= div_pulse;
    end else begin
      req.up <= req.up | ref_pulse;
      req.dn <= req.dn | div_pulse;
    end
  end

  // R4: a sampled pulse opens its request
  p_set_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && ref_pulse) |=> req.up);
  p_set_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && div_pulse) |=> req.dn);
  // R5: a finished comparison releases both requests
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req.up && req.dn && !ref_pulse) |=> !req.up);
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
  import pfd_pkg::*;
#(
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  pfd_req_t req,
  output logic     lock
);
  localparam int ERR_W  = (LOCK_TOL < 1) ? 1 : $clog2(LOCK_TOL + 1);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [ERR_W-1:0]  ERR_MAX  = '1;
  localparam logic [ERR_W-1:0]  TOL_V    = ERR_W'(LOCK_TOL);
  localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_COUNT);

  logic [ERR_W-1:0]  err_cnt;
  logic [GOOD_W-1:0] good_cnt;
  logic cmp_done, in_err;

  assign cmp_done = req.up & req.dn;
  assign in_err   = req.up ^ req.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      good_cnt <= '0;
    end else if (!run || restart) begin
      err_cnt  <= '0;
      good_cnt <= '0;
    end else if (cmp_done) begin
      err_cnt <= '0;
      if (err_cnt < TOL_V) begin
        if (good_cnt != GOOD_TOP) good_cnt <= good_cnt + 1'b1;
      end else begin
        good_cnt <= '0;
      end
    end else if (in_err && err_cnt != ERR_MAX) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  assign lock = run & (good_cnt == GOOD_TOP);

  // R9: a wide comparison removes lock
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cmp_done && err_cnt >= TOL_V) |=> !lock);
  // R8: lock only appears right after a comparison completes
  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_done));
endmodule

// File: rtl/pfd_pump_drv.sv
module pfd_pump_drv
  import pfd_pkg::*;
(
  input  logic     pump_en,
  input  pfd_req_t req,
  output logic     ext_up_n,
  output logic     ext_dn_n,
  output logic     pump_oe,
  output logic     pump_src
);
  assign ext_up_n = ~(pump_en & req.up);
  assign ext_dn_n = ~(pump_en & req.dn);
  assign pump_oe  = pump_en & (req.up ^ req.dn);
  assign pump_src = pump_oe & req.up;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps_run,
  input  logic ref_pulse,
  input  logic div_pulse,
  output logic ext_up_n,
  output logic ext_dn_n,
  output logic lock,
  output logic pump_en,
  output logic pump_oe,
  output logic pump_src,
  output logic div_restart
);
  logic     run, restart;
  pfd_req_t req;

  pfd_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .ps_run(ps_run), .run(run), .restart(restart)
  );

  pfd_req_core u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .ref_pulse(ref_pulse), .div_pulse(div_pulse), .req(req)
  );

  pfd_lock_det #(.LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .req(req), .lock(lock)
  );

  pfd_pump_drv u_drv (
    .pump_en(pump_en), .req(req), .ext_up_n(ext_up_n), .ext_dn_n(ext_dn_n),
    .pump_oe(pump_oe), .pump_src(pump_src)
  );

  assign pump_en     = run;
  assign div_restart = restart;

  // R2: standby keeps every pump path idle and lock low
  p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> (ext_up_n && ext_dn_n && !pump_oe && !lock));
  // R6: internal drive only with the pump enabled and one request open
  p_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pump_oe |-> (pump_en && (ext_up_n != ext_dn_n)));
endmodule

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
  logic clk = 1'b0;
  logic rst_n, ps_run, ref_pulse, div_pulse;
  logic ext_up_n, ext_dn_n, lock, pump_en, pump_oe, pump_src, div_restart;
  int n_run = 0, n_fail = 0, good = 0;
  localparam int TOL = 2, CNT = 4;

  always #4 clk = ~clk;

  pfd_lock_top i_pfd_lock_top (
    .clk(clk), .rst_n(rst_n), .ps_run(ps_run), .ref_pulse(ref_pulse),
    .div_pulse(div_pulse), .ext_up_n(ext_up_n), .ext_dn_n(ext_dn_n),
    .lock(lock), .pump_en(pump_en), .pump_oe(pump_oe), .pump_src(pump_src),
    .div_restart(div_restart)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic model_cmp(int width);
    if (width < TOL) good = (good < CNT) ? good + 1 : CNT;
    else good = 0;
  endtask

  task automatic compare(int d);
    int m = (d < 0) ? -d : d;
    if (d >= 0) ref_pulse = 1'b1;
    if (d <= 0) div_pulse = 1'b1;
    tick(); ref_pulse = 1'b0; div_pulse = 1'b0;
    for (int k = 1; k <= m; k++) begin
      check("R4", "lead up_n", ext_up_n, (d > 0) ? 0 : 1);
      check("R4", "lead dn_n", ext_dn_n, (d > 0) ? 1 : 0);
      check("R6", "oe single", pump_oe, 1);
      check("R6", "src", pump_src, (d > 0) ? 1 : 0);
      if (k == m) begin
        if (d > 0) div_pulse = 1'b1; else ref_pulse = 1'b1;
      end
      tick(); ref_pulse = 1'b0; div_pulse = 1'b0;
    end
    check("R5", "both active", {ext_up_n, ext_dn_n}, 2'b00);
    check("R6", "oe both", pump_oe, 0);
    tick();
    check("R5", "both cleared", {ext_up_n, ext_dn_n}, 2'b11);
    check("R6", "oe none", pump_oe, 0);
    model_cmp(m);
    check((m < TOL) ? "R8" : "R9", $sformatf("lock d=%0d (R7)", d), lock, (good == CNT));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ps_run = 1'b0; ref_pulse = 1'b0; div_pulse = 1'b0;
    repeat (3) tick();
    check("R1", "ext outs", {ext_up_n, ext_dn_n}, 2'b11);
    check("R1", "others", {lock, pump_en, pump_oe, pump_src, div_restart}, 5'b0);
    rst_n = 1'b1;
    tick();
    // standby: pulses have no effect (R2)
    ref_pulse = 1'b1; tick(); ref_pulse = 1'b0; div_pulse = 1'b1; tick(); div_pulse = 1'b0;
    check("R2", "standby ext", {ext_up_n, ext_dn_n}, 2'b11);
    check("R2", "standby en/oe/lock", {pump_en, pump_oe, lock}, 3'b0);
    // start-up strobe (R3)
    ps_run = 1'b1; tick();
    check("R3", "restart high", div_restart, 1);
    check("R3", "pump_en high", pump_en, 1);
    tick();
    check("R3", "restart single", div_restart, 0);
    // build lock (R8)
    compare(0); compare(1); compare(-1);
    check("R8", "no lock after 3", lock, 0);
    compare(0);
    check("R8", "lock after 4", lock, 1);
    compare(3);
    check("R9", "drop on wide", lock, 0);
    // sweep lead/lag spacing (R7)
    for (int pass = 0; pass < 2; pass++)
      for (int d = -5; d <= 5; d++) compare(d);
    for (int i = 0; i < 4; i++) compare((i % 2 == 0) ? 1 : -1);
    check("R8", "relock", lock, 1);
    // new pulse on the clearing edge (R5)
    ref_pulse = 1'b1; div_pulse = 1'b1; tick(); ref_pulse = 1'b0; div_pulse = 1'b0;
    check("R5", "both before clear", {ext_up_n, ext_dn_n}, 2'b00);
    ref_pulse = 1'b1; tick(); ref_pulse = 1'b0;
    model_cmp(0);
    check("R5", "rearm on clear edge", {ext_up_n, ext_dn_n}, 2'b01);
    div_pulse = 1'b1; tick(); div_pulse = 1'b0;
    check("R5", "second both", {ext_up_n, ext_dn_n}, 2'b00);
    tick();
    model_cmp(1);
    check("R8", "lock kept", lock, (good == CNT));
    // standby with a pending request (R2)
    ref_pulse = 1'b1; tick(); ref_pulse = 1'b0;
    check("R4", "pending up", ext_up_n, 0);
    ps_run = 1'b0; tick();
    check("R2", "forced inactive", {ext_up_n, ext_dn_n}, 2'b11);
    check("R2", "en/oe/lock low", {pump_en, pump_oe, lock}, 3'b0);
    div_pulse = 1'b1; tick(); div_pulse = 1'b0; tick();
    check("R2", "standby pulse", {ext_up_n, ext_dn_n, pump_oe}, 3'b110);
    good = 0;
    // restart clears and ignores a pulse in its cycle (R10)
    ps_run = 1'b1; tick();
    check("R10", "restart seen", div_restart, 1);
    ref_pulse = 1'b1; tick(); ref_pulse = 1'b0;
    check("R10", "pulse ignored", {ext_up_n, ext_dn_n}, 2'b11);
    check("R10", "lock cleared", lock, 0);
    compare(2); compare(0);
    check("R10", "count restarted", lock, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule